// File: doc/BRIEF.md
# Mixed-Page-Size Translation Buffer with Page-Table Walker

This block translates 32-bit virtual addresses to 32-bit physical addresses. It holds a fully associative table of 64 cached translations. Each cached translation covers either a 4 KB page or a 1 MB page. A lookup that hits answers in the cycle after it is accepted. A lookup that misses starts a hardware walk of a three-level page table held in external memory. The walk reads one page-table entry at a time through a simple read port.

The walk ends early, as a 1 MB mapping, when the second-level entry is a leaf. Otherwise it continues to the third level and yields a 4 KB mapping. A successful walk writes exactly one table slot. Slots are chosen in first-in, first-out order and wrap after the last one. An invalid entry at any level ends the walk with a fault and leaves the table unchanged. While a walk is running, the block refuses new lookups.

Top module: `vtlb_top`

## Requirements
- R1: After reset the table holds no translations, `req_ready` is 1, and `resp_done` and `mem_rd_req` are 0. The first lookup of any address therefore misses.
- R2: When a lookup is accepted and a table slot matches, `resp_done`=1, `resp_hit`=1 and `resp_fault`=0 are presented in the cycle following the accepting clock edge. The physical address is formed as follows:
  - for a 4 KB slot: {ppn, va[11:0]}
  - for a 1 MB slot: {ppn[19:8], va[19:0]}
- R3: A 1 MB slot compares only va[31:20]. A 4 KB slot compares va[31:12], so another 4 KB page in the same 1 MB region does not hit it.
- R4: A page-table entry uses these fields:
  - bit 0: valid
  - bit 1: leaf
  - bits 11:2: reserved, and must be zero
  - bits 31:12: page number

  The walk reads these addresses in turn:
  - first read: ROOT_PPN·4096 + va[31:26]·4
  - second read: (page number from the first read)·4096 + va[25:20]·4
  - third read: (page number from the second read)·4096 + va[19:12]·4

  The leaf bit is ignored at the first level. A usable entry at the third level always ends the walk.
- R5: Each entry read is a one-cycle `mem_rd_req` pulse with `mem_rd_addr`. The data is taken on the edge where `mem_rd_valid` is 1. With a memory that answers 100 cycles after the request:
  - a 4 KB miss responds 300 cycles after the accepting edge
  - a 1 MB miss responds 200 cycles after the accepting edge
- R6: A walk that succeeds responds with `resp_done`=1, `resp_hit`=0, `resp_fault`=0 and the translated address. It also installs the translation, so a later lookup in the same page hits.
- R7: An entry whose valid bit is 0, or whose reserved bits are nonzero, ends the walk with `resp_done`=1, `resp_fault`=1, `resp_hit`=0 and `resp_pa`=0, 100 cycles per entry read. No slot is filled, so repeating the lookup faults again with the same delay.
- R8: From the accepting edge of a miss until its response, `req_ready` is 0, and a lookup held on the request port is not taken.
- R9: Successful walks fill slots 0, 1, 2 and so on, wrapping after the last slot. Once the table is full, each new fill evicts the oldest installed translation.
- R10: A hit issues no page-table read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_va | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| resp_done | output | 1 | One-cycle pulse: a response is presented |
| resp_hit | output | 1 | Response came from a cached translation |
| resp_fault | output | 1 | Walk found an unusable entry |
| resp_pa | output | 32 | Translated physical address (0 on fault) |
| mem_rd_req | output | 1 | One-cycle page-table read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rd_valid | input | 1 | Read data is present |
| mem_rd_data | input | 32 | Page-table entry read back |

## Verification
The bench drives several kinds of lookup:
- Repeated offsets within an installed 4 KB page, which separate a hit path from a fresh walk.
- Addresses spread across a 1 MB page, including its highest word, which show that only the upper twelve bits are compared.
- An address in the next 4 KB page of the same 1 MB region, which separates the 4 KB and 1 MB compare widths.
- Faults at each of the three levels, which show both the response delay and that nothing was installed.
- A sweep of more than 64 distinct pages, followed by revisits, which separates true first-in, first-out eviction from any other choice.

While each walk runs, the bench holds a decoy lookup on the request port. If that lookup were taken early, it would show up as a premature response.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

    localparam int VA_W        = 32;
    localparam int PA_W        = 32;
    localparam int PTE_W       = 32;
    localparam int SMALL_SHIFT = 12;
    localparam int BIG_SHIFT   = 20;
    localparam int VPN_W       = VA_W - SMALL_SHIFT;
    localparam int PPN_W       = PA_W - SMALL_SHIFT;
    localparam int BIG_VPN_W   = VA_W - BIG_SHIFT;
    localparam int BIG_PPN_W   = PA_W - BIG_SHIFT;
    // walk index fields of the virtual address
    localparam int L1_LO       = 26;
    localparam int L2_LO       = BIG_SHIFT;
    localparam int L3_LO       = SMALL_SHIFT;
    localparam int IDX_W       = L2_LO - L3_LO;
    // entry bit positions
    localparam int PTE_V       = 0;
    localparam int PTE_LEAF    = 1;
    localparam int RSVD_LO     = 2;
    localparam int RSVD_HI     = SMALL_SHIFT - 1;

    typedef struct packed {
        logic             valid;
        logic             big;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_LVL1,
        WK_LVL2,
        WK_LVL3
    } walk_state_e;

    // Physical address from a page number, the page size and the virtual address.
    function automatic logic [PA_W-1:0] form_pa(input logic big,
                                                input logic [PPN_W-1:0] ppn,
                                                input logic [VA_W-1:0] va);
        if (big)
            form_pa = {ppn[PPN_W-1 -: BIG_PPN_W], va[BIG_SHIFT-1:0]};
        else
            form_pa = {ppn, va[SMALL_SHIFT-1:0]};
    endfunction

    // Byte address of entry idx inside the table at page tbl.
    function automatic logic [PA_W-1:0] pte_slot(input logic [PPN_W-1:0] tbl,
                                                 input logic [IDX_W-1:0] idx);
        pte_slot = {tbl, {SMALL_SHIFT{1'b0}}} + PA_W'({idx, 2'b00});
    endfunction

    // Entry usable: valid bit set and reserved field clear.
    function automatic logic pte_usable(input logic [PTE_W-1:0] pte);
        pte_usable = pte[PTE_V] && (pte[RSVD_HI:RSVD_LO] == '0);
    endfunction

endpackage

// File: rtl/vtlb_cam.sv
module vtlb_cam
    import vtlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int PTR_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VA_W-1:0]  lookup_va,
    output logic             hit,
    output logic [PA_W-1:0]  hit_pa,
    input  logic             fill_en,
    input  tlb_entry_t       fill_entry,
    output logic [PTR_W-1:0] fill_ptr
);

    typedef struct packed {
        tlb_entry_t [ENTRIES-1:0] ent;
        logic [PTR_W-1:0]         ptr;
    } cam_state_t;

    cam_state_t state_d, state_q;

    logic [ENTRIES-1:0] match;
    logic [PTR_W-1:0]   sel;
    tlb_entry_t         sel_ent;

    // One comparator per slot; a large page masks out the low eight page bits.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [VPN_W-1:0] mask;
        assign mask = state_q.ent[g].big
                    ? {{BIG_VPN_W{1'b1}}, {(VPN_W - BIG_VPN_W){1'b0}}}
                    : {VPN_W{1'b1}};
        assign match[g] = state_q.ent[g].valid &&
            (((state_q.ent[g].vpn ^ lookup_va[VA_W-1:SMALL_SHIFT]) & mask) == '0);
    end

    // Lowest matching slot wins.
    always_comb begin
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) sel = PTR_W'(i);
        end
    end

    assign hit      = |match;
    assign sel_ent  = state_q.ent[sel];
    assign hit_pa   = form_pa(sel_ent.big, sel_ent.ppn, lookup_va);
    assign fill_ptr = state_q.ptr;

    always_comb begin
        state_d = state_q;
        if (fill_en) begin
            state_d.ent[state_q.ptr] = fill_entry;
            state_d.ptr = (state_q.ptr == PTR_W'(ENTRIES - 1)) ? '0 : state_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/vtlb_walker.sv
module vtlb_walker
    import vtlb_pkg::*;
#(
    parameter logic [PPN_W-1:0] ROOT_PPN = 20'h00100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VA_W-1:0]  start_va,
    output logic             busy,
    output logic             mem_rd_req,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_valid,
    input  logic [PTE_W-1:0] mem_rd_data,
    output logic             end_strobe,
    output logic             end_fault,
    output logic             end_big,
    output logic [PPN_W-1:0] end_ppn,
    output logic [VA_W-1:0]  end_va
);

    typedef struct packed {
        walk_state_e      st;
        logic [VA_W-1:0]  va;
        logic             req;
        logic [PA_W-1:0]  addr;
    } walk_t;

    walk_t walk_d, walk_q;

    logic             ok;
    logic [PPN_W-1:0] nxt;

    assign ok  = pte_usable(mem_rd_data);
    assign nxt = mem_rd_data[PTE_W-1:SMALL_SHIFT];

    always_comb begin
        walk_d     = walk_q;
        walk_d.req = 1'b0;
        end_strobe = 1'b0;
        end_fault  = 1'b0;
        end_big    = 1'b0;
        end_ppn    = nxt;
        unique case (walk_q.st)
            WK_IDLE: begin
                if (start) begin
                    walk_d.st   = WK_LVL1;
                    walk_d.va   = start_va;
                    walk_d.req  = 1'b1;
                    walk_d.addr = pte_slot(ROOT_PPN, IDX_W'(start_va[VA_W-1:L1_LO]));
                end
            end
            WK_LVL1: begin
                if (mem_rd_valid) begin
                    if (!ok) begin
                        end_strobe = 1'b1;
                        end_fault  = 1'b1;
                        walk_d.st  = WK_IDLE;
                    end else begin
                        walk_d.st   = WK_LVL2;
                        walk_d.req  = 1'b1;
                        walk_d.addr = pte_slot(nxt, IDX_W'(walk_q.va[L1_LO-1:L2_LO]));
                    end
                end
            end
            WK_LVL2: begin
                if (mem_rd_valid) begin
                    if (!ok) begin
                        end_strobe = 1'b1;
                        end_fault  = 1'b1;
                        walk_d.st  = WK_IDLE;
                    end else if (mem_rd_data[PTE_LEAF]) begin
                        end_strobe = 1'b1;
                        end_big    = 1'b1;
                        walk_d.st  = WK_IDLE;
                    end else begin
                        walk_d.st   = WK_LVL3;
                        walk_d.req  = 1'b1;
                        walk_d.addr = pte_slot(nxt, IDX_W'(walk_q.va[L2_LO-1:L3_LO]));
                    end
                end
            end
            WK_LVL3: begin
                if (mem_rd_valid) begin
                    end_strobe = 1'b1;
                    end_fault  = !ok;
                    walk_d.st  = WK_IDLE;
                end
            end
            default: walk_d.st = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q    <= '0;
            walk_q.st <= WK_IDLE;
        end else begin
            walk_q    <= walk_d;
        end
    end

    assign busy        = (walk_q.st != WK_IDLE);
    assign mem_rd_req  = walk_q.req;
    assign mem_rd_addr = walk_q.addr;
    assign end_va      = walk_q.va;

endmodule

// File: rtl/vtlb_top.sv
module vtlb_top
    import vtlb_pkg::*;
#(
    parameter int               ENTRIES  = 64,
    parameter logic [19:0]      ROOT_PPN = 20'h00100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_va,
    output logic        req_ready,
    output logic        resp_done,
    output logic        resp_hit,
    output logic        resp_fault,
    output logic [31:0] resp_pa,
    output logic        mem_rd_req,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rd_valid,
    input  logic [31:0] mem_rd_data
);

    localparam int PTR_W = $clog2(ENTRIES);

    typedef struct packed {
        logic            done;
        logic            hit;
        logic            fault;
        logic [PA_W-1:0] pa;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic             accept;
    logic             cam_hit;
    logic [PA_W-1:0]  cam_pa;
    logic             walk_busy;
    logic             walk_start;
    logic             end_strobe;
    logic             end_fault;
    logic             end_big;
    logic [PPN_W-1:0] end_ppn;
    logic [VA_W-1:0]  end_va;
    logic             fill_en;
    tlb_entry_t       fill_entry;
    logic [PTR_W-1:0] fill_ptr;

    assign req_ready  = !walk_busy;
    assign accept     = req_valid && req_ready;
    assign walk_start = accept && !cam_hit;
    assign fill_en    = end_strobe && !end_fault;

    always_comb begin
        fill_entry       = '0;
        fill_entry.valid = 1'b1;
        fill_entry.big   = end_big;
        fill_entry.vpn   = end_va[VA_W-1:SMALL_SHIFT];
        fill_entry.ppn   = end_ppn;
    end

    vtlb_cam #(.ENTRIES(ENTRIES)) u_cam (
        .clk        (clk),
        .rst_n      (rst_n),
        .lookup_va  (req_va),
        .hit        (cam_hit),
        .hit_pa     (cam_pa),
        .fill_en    (fill_en),
        .fill_entry (fill_entry),
        .fill_ptr   (fill_ptr)
    );

    vtlb_walker #(.ROOT_PPN(ROOT_PPN)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (walk_start),
        .start_va     (req_va),
        .busy         (walk_busy),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .end_strobe   (end_strobe),
        .end_fault    (end_fault),
        .end_big      (end_big),
        .end_ppn      (end_ppn),
        .end_va       (end_va)
    );

    always_comb begin
        rsp_d = '0;
        if (accept && cam_hit) begin
            rsp_d.done = 1'b1;
            rsp_d.hit  = 1'b1;
            rsp_d.pa   = cam_pa;
        end else if (end_strobe) begin
            rsp_d.done  = 1'b1;
            rsp_d.fault = end_fault;
            rsp_d.pa    = end_fault ? '0 : form_pa(end_big, end_ppn, end_va);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign resp_done  = rsp_q.done;
    assign resp_hit   = rsp_q.hit;
    assign resp_fault = rsp_q.fault;
    assign resp_pa    = rsp_q.pa;

endmodule

// File: rtl/vtlb_sva.sv
module vtlb_sva #(
    parameter int ENTRIES = 64,
    localparam int PTR_W  = $clog2(ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             resp_done,
    input logic             resp_hit,
    input logic             resp_fault,
    input logic             mem_rd_req,
    input logic             fill_en,
    input logic [PTR_W-1:0] fill_ptr
);

    logic [PTR_W-1:0] ptr_after;
    assign ptr_after = (fill_ptr == PTR_W'(ENTRIES - 1)) ? '0 : fill_ptr + 1'b1;

    // R8: a table read is only outstanding while lookups are refused
    a_r8_no_accept_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !req_ready);

    // R5: each read request lasts a single cycle
    a_r5_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    // R7: a fault is a completed, non-hit response
    a_r7_fault_flags: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> (resp_done && !resp_hit));

    // R10: a hit response is never accompanied by a table read
    a_r10_hit_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_done && resp_hit) |-> !mem_rd_req);

    // R6: the end of a walk frees the request port at once
    a_r6_ready_after_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_done && !resp_hit) |-> req_ready);

    // R9: each fill advances the slot pointer by one, wrapping
    a_r9_fifo_step: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (fill_ptr == $past(ptr_after)));

    // R9: without a fill the slot pointer holds
    a_r9_fifo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_en |=> $stable(fill_ptr));

endmodule

bind vtlb_top vtlb_sva #(.ENTRIES(ENTRIES)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .resp_done  (resp_done),
    .resp_hit   (resp_hit),
    .resp_fault (resp_fault),
    .mem_rd_req (mem_rd_req),
    .fill_en    (fill_en),
    .fill_ptr   (fill_ptr)
);

// File: tb/sim_vtlb_top.sv
module sim_vtlb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          ENT        = 64;
    localparam int          MEM_LAT    = 100;
    localparam logic [19:0] ROOT_PPN   = 20'h00100;
    localparam logic [31:0] ROOT_ADDR  = {ROOT_PPN, 12'h000};
    localparam logic [31:0] DECOY_VA   = 32'h0130_0040;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_va;
    logic        req_ready;
    logic        resp_done;
    logic        resp_hit;
    logic        resp_fault;
    logic [31:0] resp_pa;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_data;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        bit [19:0] vpn;
        bit        big;
        bit [19:0] ppn;
    } ment_t;

    ment_t       tlbq[$];
    logic [31:0] pt [logic [31:0]];
    logic [31:0] next_tbl = 32'h0020_0000;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vtlb_top #(.ENTRIES(ENT), .ROOT_PPN(ROOT_PPN)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_va       (req_va),
        .req_ready    (req_ready),
        .resp_done    (resp_done),
        .resp_hit     (resp_hit),
        .resp_fault   (resp_fault),
        .resp_pa      (resp_pa),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [31:0] rd_pte(input logic [31:0] a);
        return pt.exists(a) ? pt[a] : 32'h0;
    endfunction

    function automatic void map4k(input logic [31:0] va, input logic [31:0] pa);
        logic [31:0] a1, a2, a3;
        a1 = ROOT_ADDR + 32'({va[31:26], 2'b00});
        if (!pt.exists(a1)) begin
            pt[a1] = {next_tbl[31:12], 12'h001};
            next_tbl = next_tbl + 32'h1000;
        end
        a2 = {pt[a1][31:12], 12'h000} + 32'({va[25:20], 2'b00});
        if (!pt.exists(a2)) begin
            pt[a2] = {next_tbl[31:12], 12'h001};
            next_tbl = next_tbl + 32'h1000;
        end
        a3 = {pt[a2][31:12], 12'h000} + 32'({va[19:12], 2'b00});
        pt[a3] = {pa[31:12], 12'h003};
    endfunction

    function automatic void map1m(input logic [31:0] va, input logic [31:0] pa);
        logic [31:0] a1, a2;
        a1 = ROOT_ADDR + 32'({va[31:26], 2'b00});
        if (!pt.exists(a1)) begin
            pt[a1] = {next_tbl[31:12], 12'h001};
            next_tbl = next_tbl + 32'h1000;
        end
        a2 = {pt[a1][31:12], 12'h000} + 32'({va[25:20], 2'b00});
        pt[a2] = {pa[31:20], 20'h00003};
    endfunction

    function automatic bit usable(input logic [31:0] p);
        return p[0] && (p[11:2] == 10'h0);
    endfunction

    // Behavioural walk of the bench's own table (R4, R7).
    function automatic void ref_walk(input logic [31:0] va, output int reads,
                                     output bit flt, output bit big, output bit [19:0] ppn);
        logic [31:0] p;
        big = 1'b0; flt = 1'b0; ppn = '0;
        p = rd_pte(ROOT_ADDR + 32'({va[31:26], 2'b00}));
        reads = 1;
        if (!usable(p)) begin flt = 1'b1; return; end
        p = rd_pte({p[31:12], 12'h000} + 32'({va[25:20], 2'b00}));
        reads = 2;
        if (!usable(p)) begin flt = 1'b1; return; end
        if (p[1]) begin big = 1'b1; ppn = p[31:12]; return; end
        p = rd_pte({p[31:12], 12'h000} + 32'({va[19:12], 2'b00}));
        reads = 3;
        if (!usable(p)) begin flt = 1'b1; return; end
        ppn = p[31:12];
    endfunction

    // One lookup with the response compared on every clock until it is due.
    task automatic lookup(input logic [31:0] va);
        bit          mhit, flt, big, rdy;
        bit [19:0]   ppn;
        int          reads, lat, elapsed;
        logic [31:0] pa_exp;
        mhit = 1'b0; flt = 1'b0; big = 1'b0; ppn = '0; reads = 0;
        foreach (tlbq[i]) begin
            if (!mhit && (tlbq[i].big ? (tlbq[i].vpn[19:8] == va[31:20])
                                      : (tlbq[i].vpn == va[31:12]))) begin
                mhit = 1'b1; big = tlbq[i].big; ppn = tlbq[i].ppn;
            end
        end
        if (mhit) begin
            lat = 1;
        end else begin
            ref_walk(va, reads, flt, big, ppn);
            lat = MEM_LAT * reads + 1;
            if (!flt) begin
                ment_t e;
                e.vpn = va[31:12]; e.big = big; e.ppn = ppn;
                tlbq.push_back(e);
                if (tlbq.size() > ENT) void'(tlbq.pop_front());
            end
        end
        pa_exp = flt ? 32'h0 : (big ? {ppn[19:8], va[19:0]} : {ppn, va[11:0]});

        @(negedge clk);
        req_valid = 1'b1;
        req_va    = va;
        forever begin
            rdy = req_ready;
            @(posedge clk);
            if (rdy) break;
        end
        elapsed = 0;
        forever begin
            @(negedge clk);
            elapsed++;
            if (elapsed == 1) begin
                if (lat > 1) req_va = DECOY_VA;   // R8: held while the walk runs
                else         req_valid = 1'b0;
            end
            if (elapsed == lat) begin
                req_valid = 1'b0;
                chk("R5/R7 done at expected cycle", 32'(resp_done), 32'd1);
                chk("R2/R6 hit flag", 32'(resp_hit), 32'(mhit));
                chk("R7 fault flag", 32'(resp_fault), 32'(flt));
                chk("R2/R3/R4 physical address", resp_pa, pa_exp);
                if (mhit) chk("R10 no read on hit", 32'(mem_rd_req), 32'd0);
                break;
            end else begin
                chk("R5 no early done", 32'(resp_done), 32'd0);
                chk("R8 ready low in walk", 32'(req_ready), 32'd0);
            end
        end
    endtask

    // Page-table memory: answers each read 100 cycles after the request.
    initial begin
        int          cnt;
        bit          pending;
        logic [31:0] addr;
        mem_rd_valid = 1'b0;
        mem_rd_data  = '0;
        cnt = 0; pending = 1'b0; addr = '0;
        forever begin
            @(negedge clk);
            mem_rd_valid = 1'b0;
            if (pending) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = rd_pte(addr);
                    pending      = 1'b0;
                end
            end
            if (mem_rd_req) begin
                pending = 1'b1;
                cnt     = MEM_LAT - 1;
                addr    = mem_rd_addr;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_va = '0;
        map4k(32'h0040_3000, 32'h8765_4000);
        map1m(32'h0130_0000, 32'h5A50_0000);
        for (int i = 0; i < 70; i++)
            map4k(32'h0800_0000 + 32'(i) * 32'h1000, 32'h3000_0000 + 32'(i) * 32'h1000);

        repeat (4) @(negedge clk);
        chk("R1 ready in reset", 32'(req_ready), 32'd1);
        chk("R1 no done in reset", 32'(resp_done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", 32'(req_ready), 32'd1);
        chk("R1 no done after reset", 32'(resp_done), 32'd0);
        chk("R1 no read after reset", 32'(mem_rd_req), 32'd0);

        // R1/R5/R6: first access walks three levels, then hits (R2)
        lookup(32'h0040_3ABC);
        lookup(32'h0040_3004);
        lookup(32'h0040_3FFC);
        // R3: neighbouring 4 KB page does not hit; walk faults at level 3 (R7)
        lookup(32'h0040_4000);
        // R5/R6: 1 MB leaf at level 2, then hits across the region (R3)
        lookup(32'h0134_5678);
        lookup(32'h013F_FFFC);
        lookup(32'h0130_0010);
        // R7: level-1 fault, repeated: nothing was installed
        lookup(32'hFC00_0000);
        lookup(32'hFC00_0000);
        // R7: level-2 fault
        lookup(32'h0050_0000);
        // R9: 64 new pages evict the oldest entries in order
        for (int i = 0; i < 64; i++)
            lookup(32'h0800_0000 + 32'(i) * 32'h1000 + 32'h10);
        lookup(32'h0040_3ABC);          // R9: oldest evicted, walks again
        lookup(32'h0800_2020);          // R9: still present, hits
        lookup(32'h0134_0000);          // R9: second oldest evicted
        lookup(32'h0800_0000);          // R9: first sweep page evicted by the refills
        lookup(32'h0800_3FF0);          // R9: later sweep page still present
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule